// File: doc/BRIEF.md
# Two-Stage Fetch and Next-PC Unit

This block is the front end of a two-stage, 32-bit pipelined core that runs a MIPS-style subset. It holds the fetch program counter, drives the instruction address every cycle, and captures the returned word in a 32-bit instruction register. That register is the only state handed to the second stage. The unit also decodes the control-transfer instruction in that register, evaluates its condition from the operand values the second stage reads out of the register file, and chooses the next fetch address. The choices are the sequential address, a PC-relative branch target, a region jump target or a register target.

When an instruction sits in the instruction register, the word at the following address is already being fetched. That word is always captured and executed, so the branch delay slot needs no squash logic, and the fetch PC is never flushed. The fetch PC at that point equals the address of the control instruction plus 4. It serves as the base for branch targets and jump regions, and plus 4 again it gives the return address for linking jumps.

Top module: `fetch_npc_unit`

## Requirements
- R1: While `rst` is high, on each clock edge `iaddr_o` becomes 0x00001000 and `ir_o` becomes 0x00000000 (a NOP). These values are visible in the first cycle after `rst` falls.
- R2: When `ir_o` holds no taken control transfer, the next `iaddr_o` is the current `iaddr_o` plus 4.
- R3: After every clock edge outside reset, `ir_o` equals the `inst_i` value that was present before that edge.
- R4: With opcode bits [31:26] of `ir_o` equal to 000010 or 000011 (region jumps), the next `iaddr_o` is {current `iaddr_o`[31:28], `ir_o`[25:0], 2'b00}.
- R5: For a taken conditional branch, the next `iaddr_o` is the current `iaddr_o` plus the sign-extended `ir_o`[15:0] times 4. For a branch that is not taken, it is the current `iaddr_o` plus 4.
- R6: Opcode 000100 is taken when `rs_val_i` equals `rt_val_i`, and opcode 000101 is taken when they differ.
- R7: These branches test `rs_val_i` as a signed number against zero. Opcode 000110 is taken when it is at most zero and opcode 000111 when it is above zero. Opcode 000001 with `ir_o`[20:16]=00000 is taken when it is below zero, and with `ir_o`[20:16]=00001 when it is at least zero.
- R8: With opcode 000000 and function bits [5:0] equal to 001000 or 001001 (register jumps), the next `iaddr_o` is {`rs_val_i`[31:2], 2'b00}.
- R9: The word fetched while a control transfer sits in `ir_o` is always loaded into `ir_o` on the next edge, whatever the transfer does.
- R10: `link_o` always equals `iaddr_o` plus 4, which is the address of the control instruction in `ir_o` plus 8.
- R11: `iaddr_o`[1:0] is always 00, even when the register target has nonzero low bits.
- R12: Other words do not redirect fetch. This covers other opcodes, other function codes under opcode 000000, and other `ir_o`[20:16] codes under opcode 000001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inst_i | input | 32 | Instruction word returned for `iaddr_o` |
| rs_val_i | input | 32 | First source operand of the instruction in `ir_o` |
| rt_val_i | input | 32 | Second source operand of the instruction in `ir_o` |
| iaddr_o | output | 32 | Fetch address (word aligned) |
| ir_o | output | 32 | Instruction register, handed to the second stage |
| link_o | output | 32 | Return address for linking jumps |

## Verification
The hardest case to reach from the ports is a redirect whose target depends on state left behind by an earlier redirect. One example is a region jump that must carry high PC bits, which only a previous register jump can set. Another is a backward branch taken from an arbitrary address. The stimulus table gets there by chaining its entries in one unbroken run. Each control word is followed by a plain delay-slot word, and the run is never reset in between. Because of this, a register jump to a high address leaves the PC where the following region jump takes its top bits from. Every expected address is derived from the address observed just before the redirect.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  localparam int XLEN    = 32;
  localparam int OP_W    = 6;
  localparam int RSEL_W  = 5;
  localparam int IMM_W   = 16;
  localparam int IDX_W   = 26;
  localparam int REGN_W  = 4;   // PC bits kept by region jumps
  localparam int ALIGN_W = 2;   // byte offset inside a word
  localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(4);

  localparam logic [OP_W-1:0] OP_SPECIAL = 6'b000000;
  localparam logic [OP_W-1:0] OP_REGIMM  = 6'b000001;
  localparam logic [OP_W-1:0] OP_J       = 6'b000010;
  localparam logic [OP_W-1:0] OP_JAL     = 6'b000011;
  localparam logic [OP_W-1:0] OP_BEQ     = 6'b000100;
  localparam logic [OP_W-1:0] OP_BNE     = 6'b000101;
  localparam logic [OP_W-1:0] OP_BLEZ    = 6'b000110;
  localparam logic [OP_W-1:0] OP_BGTZ    = 6'b000111;

  localparam logic [OP_W-1:0]   FN_JR   = 6'b001000;
  localparam logic [OP_W-1:0]   FN_JALR = 6'b001001;
  localparam logic [RSEL_W-1:0] RI_LTZ  = 5'b00000;
  localparam logic [RSEL_W-1:0] RI_GEZ  = 5'b00001;

  typedef enum logic [1:0] {
    NPC_SEQ,
    NPC_BRANCH,
    NPC_JUMP,
    NPC_REG
  } npc_sel_e;

  typedef enum logic [2:0] {
    BC_NONE,
    BC_EQ,
    BC_NE,
    BC_LEZ,
    BC_GTZ,
    BC_LTZ,
    BC_GEZ
  } cond_e;

  typedef struct packed {
    npc_sel_e sel;
    cond_e    cond;
  } redir_t;

  function automatic logic [XLEN-1:0] f_seq(input logic [XLEN-1:0] pc);
    return pc + WORD_BYTES;
  endfunction

  function automatic logic [XLEN-1:0] f_branch_tgt(input logic [XLEN-1:0] pc,
                                                   input logic [IMM_W-1:0] off);
    logic [XLEN-1:0] sx;
    sx = {{(XLEN-IMM_W-ALIGN_W){off[IMM_W-1]}}, off, {ALIGN_W{1'b0}}};
    return pc + sx;
  endfunction

  function automatic logic [XLEN-1:0] f_jump_tgt(input logic [XLEN-1:0] pc,
                                                 input logic [IDX_W-1:0] idx);
    return {pc[XLEN-1 -: REGN_W], idx, {ALIGN_W{1'b0}}};
  endfunction

  function automatic logic [XLEN-1:0] f_reg_tgt(input logic [XLEN-ALIGN_W-1:0] hi);
    return {hi, {ALIGN_W{1'b0}}};
  endfunction

  function automatic logic f_cond(input cond_e c,
                                  input logic [XLEN-1:0] a,
                                  input logic [XLEN-1:0] b);
    logic neg, zero;
    neg  = a[XLEN-1];
    zero = (a == '0);
    case (c)
      BC_EQ:   return a == b;
      BC_NE:   return a != b;
      BC_LEZ:  return neg | zero;
      BC_GTZ:  return ~neg & ~zero;
      BC_LTZ:  return neg;
      BC_GEZ:  return ~neg;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fetch_decode.sv
module fetch_decode
  import fetch_pkg::*;
(
  input  logic [OP_W-1:0]   op_i,
  input  logic [RSEL_W-1:0] rsel_i,
  input  logic [OP_W-1:0]   funct_i,
  output redir_t            ctl_o
);

  always_comb begin
    ctl_o.sel  = NPC_SEQ;
    ctl_o.cond = BC_NONE;
    case (op_i)
      OP_SPECIAL: begin
        if (funct_i == FN_JR || funct_i == FN_JALR) ctl_o.sel = NPC_REG;
      end
      OP_REGIMM: begin
        if (rsel_i == RI_LTZ) begin
          ctl_o.sel  = NPC_BRANCH;
          ctl_o.cond = BC_LTZ;
        end else if (rsel_i == RI_GEZ) begin
          ctl_o.sel  = NPC_BRANCH;
          ctl_o.cond = BC_GEZ;
        end
      end
      OP_J, OP_JAL: ctl_o.sel = NPC_JUMP;
      OP_BEQ: begin
        ctl_o.sel  = NPC_BRANCH;
        ctl_o.cond = BC_EQ;
      end
      OP_BNE: begin
        ctl_o.sel  = NPC_BRANCH;
        ctl_o.cond = BC_NE;
      end
      OP_BLEZ: begin
        ctl_o.sel  = NPC_BRANCH;
        ctl_o.cond = BC_LEZ;
      end
      OP_BGTZ: begin
        ctl_o.sel  = NPC_BRANCH;
        ctl_o.cond = BC_GTZ;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/branch_eval.sv
module branch_eval
  import fetch_pkg::*;
(
  input  cond_e           cond_i,
  input  logic [XLEN-1:0] rs_i,
  input  logic [XLEN-1:0] rt_i,
  output logic            taken_o
);

  always_comb taken_o = f_cond(cond_i, rs_i, rt_i);

endmodule

// File: rtl/next_pc_mux.sv
module next_pc_mux
  import fetch_pkg::*;
(
  input  npc_sel_e               sel_i,
  input  logic                   taken_i,
  input  logic [XLEN-1:0]        pc_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [XLEN-ALIGN_W-1:0] rs_hi_i,
  output logic [XLEN-1:0]        npc_o,
  output logic                   redirect_o
);

  logic [XLEN-1:0] seq_w;
  logic [XLEN-1:0] br_w;
  logic [XLEN-1:0] jmp_w;
  logic [XLEN-1:0] reg_w;

  always_comb begin
    seq_w = f_seq(pc_i);
    br_w  = f_branch_tgt(pc_i, idx_i[IMM_W-1:0]);
    jmp_w = f_jump_tgt(pc_i, idx_i);
    reg_w = f_reg_tgt(rs_hi_i);
  end

  always_comb begin
    npc_o      = seq_w;
    redirect_o = 1'b0;
    case (sel_i)
      NPC_BRANCH: begin
        if (taken_i) begin
          npc_o      = br_w;
          redirect_o = 1'b1;
        end
      end
      NPC_JUMP: begin
        npc_o      = jmp_w;
        redirect_o = 1'b1;
      end
      NPC_REG: begin
        npc_o      = reg_w;
        redirect_o = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/fetch_state.sv
module fetch_state
  import fetch_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_1000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] npc_i,
  input  logic [XLEN-1:0] inst_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] ir_o
);

  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] ir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= RESET_VEC;
      ir_q <= '0;
    end else begin
      pc_q <= npc_i;
      ir_q <= inst_i;
    end
  end

  assign pc_o = pc_q;
  assign ir_o = ir_q;

  AST_RESET_VEC: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pc_q == RESET_VEC && ir_q == '0)); // R1

endmodule

// File: rtl/fetch_npc_unit.sv
module fetch_npc_unit
  import fetch_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_1000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] inst_i,
  input  logic [XLEN-1:0] rs_val_i,
  input  logic [XLEN-1:0] rt_val_i,
  output logic [XLEN-1:0] iaddr_o,
  output logic [XLEN-1:0] ir_o,
  output logic [XLEN-1:0] link_o
);

  redir_t          ctl_w;
  logic            taken_w;
  logic            redirect_w;
  logic [XLEN-1:0] npc_w;
  logic [XLEN-1:0] pc_w;
  logic [XLEN-1:0] ir_w;

  // named events for the checks below
  logic jump_w;
  logic jreg_w;

  fetch_decode u_dec (
    .op_i    (ir_w[XLEN-1 -: OP_W]),
    .rsel_i  (ir_w[20:16]),
    .funct_i (ir_w[OP_W-1:0]),
    .ctl_o   (ctl_w)
  );

  branch_eval u_cond (
    .cond_i  (ctl_w.cond),
    .rs_i    (rs_val_i),
    .rt_i    (rt_val_i),
    .taken_o (taken_w)
  );

  next_pc_mux u_mux (
    .sel_i      (ctl_w.sel),
    .taken_i    (taken_w),
    .pc_i       (pc_w),
    .idx_i      (ir_w[IDX_W-1:0]),
    .rs_hi_i    (rs_val_i[XLEN-1:ALIGN_W]),
    .npc_o      (npc_w),
    .redirect_o (redirect_w)
  );

  fetch_state #(.RESET_VEC(RESET_VEC)) u_state (
    .clk    (clk),
    .rst    (rst),
    .npc_i  (npc_w),
    .inst_i (inst_i),
    .pc_o   (pc_w),
    .ir_o   (ir_w)
  );

  assign jump_w  = (ctl_w.sel == NPC_JUMP);
  assign jreg_w  = (ctl_w.sel == NPC_REG);
  assign iaddr_o = pc_w;
  assign ir_o    = ir_w;
  assign link_o  = f_seq(pc_w);

  AST_ALIGNED_FETCH: assert property (@(posedge clk) disable iff (rst)
    iaddr_o[ALIGN_W-1:0] == '0); // R11

  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(redirect_w)) |-> iaddr_o == $past(iaddr_o) + 32'd4); // R2

  AST_JUMP_FIELD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(jump_w)) |->
      iaddr_o == {$past(iaddr_o[31:28]), $past(ir_o[25:0]), 2'b00}); // R4

  AST_REG_TARGET: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(jreg_w)) |->
      iaddr_o == {$past(rs_val_i[31:2]), 2'b00}); // R8

  AST_SLOT_KEPT: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ir_o == $past(inst_i)); // R9

  AST_LINK_SKIPS_SLOT: assert property (@(posedge clk) disable iff (rst)
    link_o == iaddr_o + 32'd4); // R10

endmodule

// File: tb/fetch_npc_unit_test.sv
`timescale 1ns/1ps
module fetch_npc_unit_test;

  typedef struct packed {
    logic [31:0] w;
    logic [31:0] rs;
    logic [31:0] rt;
    logic        tk;
  } vec_t;

  localparam int NV = 21;
  localparam logic [31:0] SLOT = 32'h2401_0001;
  localparam vec_t VEC [0:NV-1] = '{
    '{32'h1022_0003, 32'h0000_0005, 32'h0000_0005, 1'b1},
    '{32'h1022_0003, 32'h0000_0005, 32'h0000_0006, 1'b0},
    '{32'h1422_FFFC, 32'h0000_0001, 32'h0000_0002, 1'b1},
    '{32'h1422_FFFC, 32'h0000_0007, 32'h0000_0007, 1'b0},
    '{32'h1820_0010, 32'h0000_0000, 32'h0000_0000, 1'b1},
    '{32'h1820_0010, 32'h0000_0001, 32'h0000_0000, 1'b0},
    '{32'h1820_0010, 32'h8000_0000, 32'h0000_0000, 1'b1},
    '{32'h1C20_0008, 32'h0000_0001, 32'h0000_0000, 1'b1},
    '{32'h1C20_0008, 32'h0000_0000, 32'h0000_0000, 1'b0},
    '{32'h1C20_0008, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0},
    '{32'h0420_0005, 32'hFFFF_FFFE, 32'h0000_0000, 1'b1},
    '{32'h0420_0005, 32'h0000_0000, 32'h0000_0000, 1'b0},
    '{32'h0421_0005, 32'h0000_0000, 32'h0000_0000, 1'b1},
    '{32'h0421_0005, 32'h8000_0000, 32'h0000_0000, 1'b0},
    '{32'h0020_0008, 32'hA000_1003, 32'h0000_0000, 1'b1},
    '{32'h0800_0400, 32'h0000_0000, 32'h0000_0000, 1'b1},
    '{32'h0C12_3456, 32'h0000_0000, 32'h0000_0000, 1'b1},
    '{32'h0020_F809, 32'h0000_3000, 32'h0000_0000, 1'b1},
    '{32'h2442_0001, 32'h0000_0000, 32'h0000_0000, 1'b0},
    '{32'h0022_1021, 32'h0000_0000, 32'h0000_0000, 1'b0},
    '{32'h0422_0005, 32'h0000_0000, 32'h0000_0000, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] inst_i = '0;
  logic [31:0] rs_val_i = '0;
  logic [31:0] rt_val_i = '0;
  logic [31:0] iaddr_o, ir_o, link_o;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  fetch_npc_unit uut (
    .clk      (clk),
    .rst      (rst),
    .inst_i   (inst_i),
    .rs_val_i (rs_val_i),
    .rt_val_i (rt_val_i),
    .iaddr_o  (iaddr_o),
    .ir_o     (ir_o),
    .link_o   (link_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] want(input logic [31:0] pc, input logic [31:0] w,
                                      input logic [31:0] rs, input logic tk);
    logic [31:0] off;
    if (!tk) return pc + 32'd4;
    off = {{14{w[15]}}, w[15:0], 2'b00};
    case (w[31:26])
      6'd2, 6'd3: return {pc[31:28], w[25:0], 2'b00};
      6'd0:       return rs & 32'hFFFF_FFFC;
      default:    return pc + off;
    endcase
  endfunction

  function automatic string tag_of(input logic [31:0] w);
    case (w[31:26])
      6'd4, 6'd5:       return "R5 R6 target";
      6'd6, 6'd7:       return "R5 R7 target";
      6'd1:             return (w[20:17] == 4'd0) ? "R5 R7 target" : "R12 target";
      6'd2, 6'd3:       return "R4 target";
      6'd0:             return (w[5:1] == 5'b00100) ? "R8 target" : "R12 target";
      default:          return "R12 target";
    endcase
  endfunction

  initial begin : wdog
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=done", 20000);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] pc0, pcb;
    repeat (3) @(negedge clk);
    chk("R1 reset iaddr", iaddr_o, 32'h0000_1000);
    chk("R1 reset ir", ir_o, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      pc0    = iaddr_o;
      inst_i = VEC[i].w;
      @(negedge clk);
      chk("R3 ir capture", ir_o, VEC[i].w);
      chk("R2 sequential", iaddr_o, pc0 + 32'd4);
      pcb = iaddr_o;
      chk("R10 link", link_o, pcb + 32'd4);
      inst_i   = SLOT;
      rs_val_i = VEC[i].rs;
      rt_val_i = VEC[i].rt;
      @(negedge clk);
      chk("R9 slot kept", ir_o, SLOT);
      chk(tag_of(VEC[i].w), iaddr_o, want(pcb, VEC[i].w, VEC[i].rs, VEC[i].tk));
      chk("R11 aligned", {30'd0, iaddr_o[1:0]}, 32'd0);
      rs_val_i = '0;
      rt_val_i = '0;
    end

    // directed: top PC bits come from the register jump above
    pc0 = iaddr_o;
    chk("R4 region bits", {28'd0, pc0[31:28]}, 32'd0);

    // directed: register jump with odd target low bits
    inst_i = 32'h0060_0008;
    @(negedge clk);
    inst_i   = SLOT;
    rs_val_i = 32'h0000_5557;
    @(negedge clk);
    chk("R11 low bits dropped", iaddr_o, 32'h0000_5554);
    chk("R8 register target", ir_o, SLOT);
    rs_val_i = '0;

    // directed: reset in the middle of a jump
    inst_i = 32'h0800_0100;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid reset iaddr", iaddr_o, 32'h0000_1000);
    chk("R1 mid reset ir", ir_o, 32'h0);
    rst    = 1'b0;
    inst_i = SLOT;
    @(negedge clk);
    chk("R1 R2 restart", iaddr_o, 32'h0000_1004);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule